// File: doc/BRIEF.md
# Configurable Logic-Cell Register Bank

This block is the storage stage of a programmable logic cell. It holds nine one-bit storage elements. Elements 0 to 7 can act as level-sensitive latches or as edge-triggered flip-flops. Element 8 is always an edge-triggered flip-flop. The mode, the clock polarity, the data source and the set/reset behaviour all come from a static configuration word `cfg`. That word is written while the bank is idle and then held.

Elements 0 to 7 form two groups of `GW` elements. Each group has its own clock-enable, set/reset and select line. Element 8 shares the lines of group 0 but has its own enable gating. Each element has its own "set/reset value". Both local set/reset and the global reset load that value. Each control line can be made active-low by a configuration bit.

Top module: `lcell_regbank`

## Requirements
- R1: The `cfg` word is laid out as follows, starting at bit 0:
  - bit 0: invert clock
  - bit 1: latch mode
  - bit 2: synchronous set/reset
  - bit 3: set/reset wins over clock enable
  - bits 5:4: data source
  - bit 6: select steering
  - bit 7: global reset enable
  - bits 16:8: per-element set/reset value, one bit per element 0..8
  - bits 19:17: clock-enable use for groups 0, 1 and 8
  - bits 22:20: set/reset use for groups 0, 1 and 8
  - bits 24:23: CE active-low
  - bits 26:25: LSR active-low
  - bits 28:27: SEL active-low

  With the global reset enabled and `gsr_n` low, every element takes its set/reset value at once, without a clock.
- R2: With the global reset disabled, `gsr_n` has no effect on any element.
- R3: In flip-flop mode all nine elements capture on the rising clock edge, or on the falling edge when the clock is inverted. They ignore the other edge.
- R4: In latch mode, elements 0..7 are transparent while the clock is high (low when inverted) and hold otherwise. Element 8 stays edge-triggered.
- R5: The data source field selects the input for all elements:
  - 0: constant 0
  - 1: constant 1
  - 2: `lut_f`
  - 3: `din`

  Element 8 takes `d8` for sources 2 and 3, and the constant otherwise.
- R6: With steering on and a source of 2 or 3, group g takes `din` when its select line is active and `lut_f` otherwise.
- R7: An element whose group has clock-enable use on and an inactive CE keeps its value on a clock event. A group with clock-enable use off always loads.
- R8: In synchronous mode, an active set/reset changes an element only on a clock event.
- R9: In asynchronous mode, an active set/reset forces the element to its set/reset value at once, whatever the clock and CE.
- R10: In synchronous mode, when set/reset is active and CE is inactive, the element is set/reset if set/reset has priority, and holds if CE has priority.
- R11: The value loaded by set/reset or by the global reset is chosen per element by its own bit of the set/reset value field.
- R12: CE[0] and LSR[0] serve elements 3:0 and element 8. CE[1] and LSR[1] serve elements 7:4. A group with set/reset use off ignores its LSR line.
- R13: A set active-low bit inverts the matching CE, LSR or SEL line, so that a low level is the active one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared bank clock |
| gsr_n | input | 1 | Global reset, active-low, asynchronous |
| cfg | input | 2*GW+21 (29) | Static configuration word |
| lut_f | input | 2*GW (8) | LUT outputs for elements 0..7 |
| din | input | 2*GW (8) | Direct data for elements 0..7 |
| d8 | input | 1 | Dedicated data input of element 8 |
| ce | input | 2 | Clock enables, one per group |
| lsr | input | 2 | Local set/reset lines, one per group |
| sel | input | 2 | Source select lines, one per group |
| q | output | 2*GW+1 (9) | Element outputs, element 8 on top |

## Verification
The bench builds the bank with the default GW of 4. This gives two nibble groups plus element 8, so the CE and LSR lines can be driven to distinct values and the group boundary is visible in one 9-bit output. A set/reset pattern such as 0x15A makes every element's own value observable, and the separate effect of each group's gating shows up in a single output word. Latch transparency and edge polarity are probed between clock edges, at the half-cycle where the correct and the wrong behaviour differ.

// File: rtl/lcell_regbank.sv
module lcell_regbank #(
  parameter int GW = 4,
  localparam int N       = 2 * GW,
  localparam int NT      = N + 1,
  localparam int P_INV   = 0,
  localparam int P_LAT   = 1,
  localparam int P_SYNC  = 2,
  localparam int P_PRIO  = 3,
  localparam int P_SRC   = 4,
  localparam int P_STEER = 6,
  localparam int P_GEN   = 7,
  localparam int P_SV    = 8,
  localparam int P_CEU   = P_SV + NT,
  localparam int P_LSRU  = P_CEU + 3,
  localparam int P_CELO  = P_LSRU + 3,
  localparam int P_LSRLO = P_CELO + 2,
  localparam int P_SELLO = P_LSRLO + 2,
  localparam int CW      = P_SELLO + 2
) (
  input  logic          clk,
  input  logic          gsr_n,
  input  logic [CW-1:0] cfg,
  input  logic [N-1:0]  lut_f,
  input  logic [N-1:0]  din,
  input  logic          d8,
  input  logic [1:0]    ce,
  input  logic [1:0]    lsr,
  input  logic [1:0]    sel,
  output logic [NT-1:0] q
);
  logic clk_e, gsr_hit, sync, prio, steer, lat;
  logic [1:0] src, ce_a, lsr_a, sel_a;
  logic [2:0] ceu, lsru, g_en, g_rs;
  logic [NT-1:0] sv, en_e, rs_e, d_e, ld_e, nx_e, ar_e;

  assign clk_e   = clk ^ cfg[P_INV];
  assign lat     = cfg[P_LAT];
  assign sync    = cfg[P_SYNC];
  assign prio    = cfg[P_PRIO];
  assign src     = cfg[P_SRC +: 2];
  assign steer   = cfg[P_STEER];
  assign gsr_hit = cfg[P_GEN] & ~gsr_n;
  assign sv      = cfg[P_SV +: NT];
  assign ceu     = cfg[P_CEU +: 3];
  assign lsru    = cfg[P_LSRU +: 3];
  assign ce_a    = ce  ^ cfg[P_CELO +: 2];
  assign lsr_a   = lsr ^ cfg[P_LSRLO +: 2];
  assign sel_a   = sel ^ cfg[P_SELLO +: 2];

  // group 2 is element 8, fed by the group-0 lines
  assign g_en = ~ceu | {ce_a[0], ce_a};
  assign g_rs = lsru & {lsr_a[0], lsr_a};

  generate
    for (genvar i = 0; i < NT; i++) begin : g_el
      localparam int G = (i < N) ? i / GW : 2;
      logic fq;

      assign en_e[i] = g_en[G];
      assign rs_e[i] = g_rs[G];
      if (i < N) begin : g_dat
        assign d_e[i] = src[1] ? ((steer ? sel_a[G] : src[0]) ? din[i] : lut_f[i]) : src[0];
      end else begin : g_d8
        assign d_e[i] = src[1] ? d8 : src[0];
      end
      assign ld_e[i] = prio ? (en_e[i] | (rs_e[i] & sync)) : en_e[i];
      assign nx_e[i] = (rs_e[i] & sync) ? sv[i] : d_e[i];
      assign ar_e[i] = gsr_hit | (rs_e[i] & ~sync);

      always_ff @(posedge clk_e or posedge ar_e[i]) begin
        if (ar_e[i])      fq <= sv[i];
        else if (ld_e[i]) fq <= nx_e[i];
      end

      if (i < N) begin : g_lat
        logic lq;
        always_latch begin
          if (ar_e[i])               lq <= sv[i];
          else if (clk_e && ld_e[i]) lq <= nx_e[i];
        end
        assign q[i] = lat ? lq : fq;
      end else begin : g_ff
        assign q[i] = fq;
      end
    end
  endgenerate

  p_ce_hold_r7: assert property (@(posedge clk) disable iff (gsr_hit)
    (!cfg[P_INV] && !lat && sync && !en_e[0] && !rs_e[0])
    |=> (q[GW-1:0] == $past(q[GW-1:0]) || !$stable(cfg)));

  p_bit8_hold_r7: assert property (@(posedge clk) disable iff (gsr_hit)
    (!cfg[P_INV] && sync && !en_e[N] && !rs_e[N])
    |=> (q[N] == $past(q[N]) || !$stable(cfg)));

  p_sync_lsr_r10: assert property (@(posedge clk) disable iff (gsr_hit)
    (!cfg[P_INV] && !lat && sync && rs_e[0] && (prio || en_e[0]))
    |=> (q[GW-1:0] == $past(sv[GW-1:0]) || !$stable(cfg)));

  p_async_lsr_r9: assert property (@(posedge clk) disable iff (gsr_hit)
    (!sync && rs_e[GW] && $past(rs_e[GW]) && $stable(cfg))
    |-> (q[N-1:GW] == sv[N-1:GW]));

  p_const_one_r5: assert property (@(posedge clk) disable iff (gsr_hit)
    (src == 2'd1 && !cfg[P_INV] && !lat && sync && (&en_e) && !(|rs_e))
    |=> ((&q) || !$stable(cfg)));
endmodule

// File: tb/tb_lcell_regbank.sv
module tb_lcell_regbank;
  logic clk = 1'b0;
  logic gsr_n = 1'b1;
  logic [28:0] cfg;
  logic [7:0] lut_f = '0, din = '0;
  logic d8 = 1'b0;
  logic [1:0] ce = 2'b11, lsr = 2'b00, sel = 2'b00;
  logic [8:0] q;

  logic f_inv = 0, f_lat = 0, f_sync = 0, f_prio = 0, f_steer = 0, f_gen = 1;
  logic [1:0] f_src = 0, f_celo = 0, f_lsrlo = 0, f_sello = 0;
  logic [8:0] f_sv = 9'h1A5;
  logic [2:0] f_ceu = 0, f_lsru = 0;

  int checks = 0, fails = 0;

  always_comb cfg = {f_sello, f_lsrlo, f_celo, f_lsru, f_ceu, f_sv,
                     f_gen, f_steer, f_src, f_prio, f_sync, f_lat, f_inv};

  always #5 clk = ~clk;

  lcell_regbank dut (.clk(clk), .gsr_n(gsr_n), .cfg(cfg), .lut_f(lut_f), .din(din),
                     .d8(d8), .ce(ce), .lsr(lsr), .sel(sel), .q(q));

  task automatic chk(input string req, input logic [8:0] exp);
    checks++;
    if (q !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, q, exp, $time);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #2;
  endtask

  task automatic plain(input logic [1:0] s);
    f_inv = 0; f_lat = 0; f_sync = 0; f_prio = 0; f_steer = 0; f_gen = 1;
    f_src = s; f_celo = 0; f_lsrlo = 0; f_sello = 0; f_ceu = 0; f_lsru = 0;
    ce = 2'b11; lsr = 2'b00; sel = 2'b00;
  endtask

  task automatic t_reset;
    #1 gsr_n = 1'b0;
    #2 chk("R1 global reset value", 9'h1A5);
    step; gsr_n = 1'b1;
    step; chk("R5 constant 0 source", 9'h000);
  endtask

  task automatic t_gsr;
    plain(2'd1); f_gen = 0;
    step; step; chk("R5 constant 1 source", 9'h1FF);
    gsr_n = 1'b0; #1 chk("R2 disabled global reset ignored", 9'h1FF);
    gsr_n = 1'b1; f_gen = 1; f_sv = 9'h0F0; #1;
    gsr_n = 1'b0; #1 chk("R11 per-element reset value", 9'h0F0);
    gsr_n = 1'b1;
    step; step; chk("R5 constant 1 after reset", 9'h1FF);
  endtask

  task automatic t_src;
    plain(2'd2); lut_f = 8'h3C; din = 8'hC3; d8 = 1;
    step; step; chk("R5 LUT source", 9'h13C);
    f_src = 2'd3; step; step; chk("R5 direct source", 9'h1C3);
    f_src = 2'd1; d8 = 0; step; step; chk("R5 constant 1 element 8", 9'h1FF);
    f_src = 2'd0; step; step; chk("R5 constant 0 all", 9'h000);
  endtask

  task automatic t_steer;
    plain(2'd2); f_steer = 1; sel = 2'b01; lut_f = 8'h3C; din = 8'hC3; d8 = 0;
    step; step; chk("R6 select steering", 9'h033);
    f_sello = 2'b11; step; step; chk("R13 select active-low", 9'h0CC);
  endtask

  task automatic t_edge;
    plain(2'd2); f_inv = 1; lut_f = 0; d8 = 0;
    step; step; step; chk("R3 settle inverted", 9'h000);
    lut_f = 8'hAA; d8 = 1;
    @(negedge clk); #1 chk("R3 falling edge capture", 9'h1AA);
    lut_f = 8'h55; d8 = 0;
    @(posedge clk); #1 chk("R3 rising edge ignored when inverted", 9'h1AA);
    @(negedge clk); #1 chk("R3 falling edge capture again", 9'h055);
    f_inv = 0;
    @(posedge clk); #2 lut_f = 8'h0F; d8 = 1;
    @(negedge clk); #1 chk("R3 falling edge ignored", 9'h055);
    @(posedge clk); #1 chk("R3 rising edge capture", 9'h10F);
    f_lat = 1; lut_f = 8'h11; d8 = 0;
    #1 chk("R4 latch transparent high", 9'h111);
    @(negedge clk); #1 lut_f = 8'h22;
    #1 chk("R4 latch opaque low", 9'h111);
    @(posedge clk); #1 chk("R4 reopen and element 8 edge", 9'h022);
    f_inv = 1; lut_f = 8'h44;
    #1 chk("R4 inverted latch opaque high", 9'h022);
    @(negedge clk); #1 chk("R4 inverted latch transparent", 9'h044);
    lut_f = 8'h66; #1 chk("R4 inverted latch follows", 9'h066);
  endtask

  task automatic t_ce;
    plain(2'd2); f_sync = 1; f_ceu = 3'b111; lut_f = 0; d8 = 0;
    step; step; step; chk("R7 settle", 9'h000);
    ce = 2'b01; lut_f = 8'hFF; d8 = 1;
    step; chk("R12 group 0 and element 8 on CE0", 9'h10F);
    ce = 2'b10; lut_f = 8'hA0; d8 = 0;
    step; chk("R7 hold with CE inactive", 9'h1AF);
    f_ceu = 3'b000; ce = 2'b00; lut_f = 0;
    step; step; chk("R7 CE use off ignores CE", 9'h000);
    f_ceu = 3'b111; f_celo = 2'b11; ce = 2'b11; lut_f = 8'hFF; d8 = 1;
    step; step; chk("R13 CE active-low inactive", 9'h000);
    ce = 2'b00; step; chk("R13 CE active-low active", 9'h1FF);
  endtask

  task automatic t_sync;
    plain(2'd2); f_sync = 1; f_prio = 1; f_sv = 9'h15A; f_ceu = 3'b111; f_lsru = 3'b111;
    lut_f = 0; d8 = 0;
    step; step; step; chk("R8 settle", 9'h000);
    lsr = 2'b01; #1 chk("R8 no immediate effect", 9'h000);
    step; chk("R8 group 0 set on edge", 9'h10A);
    lsr = 2'b00; step; chk("R8 clear to data", 9'h000);
    ce = 2'b00; lsr = 2'b11; step; chk("R10 set/reset over CE", 9'h15A);
    ce = 2'b11; lsr = 2'b00; step; chk("R10 clear", 9'h000);
    f_prio = 0; ce = 2'b00; lsr = 2'b11; step; step; chk("R10 CE priority holds", 9'h000);
    ce = 2'b11; step; chk("R10 CE priority with CE on", 9'h15A);
    f_lsru = 3'b010; step; step; chk("R12 set/reset use per group", 9'h050);
  endtask

  task automatic t_async;
    plain(2'd2); f_sync = 0; f_sv = 9'h15A; f_ceu = 3'b111; f_lsru = 3'b111;
    lut_f = 0; d8 = 0;
    step; step; step; chk("R9 settle", 9'h000);
    ce = 2'b00; lsr = 2'b01;
    #1 chk("R9 async set immediate", 9'h10A);
    lsr = 2'b00; step; chk("R9 value kept after release", 9'h10A);
    ce = 2'b11; step; chk("R9 reload", 9'h000);
    f_lsru = 3'b000; f_lsrlo = 2'b11; #1;
    lsr = 2'b11; #1;
    f_lsru = 3'b111; step; step; chk("R13 LSR active-low inactive", 9'h000);
    lsr = 2'b01; #1 chk("R13 LSR active-low group 1", 9'h050);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_gsr();
    t_src();
    t_steer();
    t_edge();
    t_ce();
    t_sync();
    t_async();
    finish_run();
  end
endmodule